// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block lets an external I2C master read and write a local 256-entry byte register space. It samples the bus clock and data lines through synchronisers, finds START, STOP and clock edges in the system clock domain, and pulls the data line low only when it acknowledges or sends a zero bit. Its 7-bit bus address is a parameter. The system clock must run at least ten times faster than the bus clock.

A write transfer carries the address byte, then a pointer byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transfer does not carry a pointer of its own. It continues from the pointer left by earlier traffic, which is usually set by a short write just before a repeated START. It sends one byte per pointer position until the master answers a byte with NACK. The register file on the local side is reached through a combinational read port and a one-cycle write strobe.

Top module: `i2cRegTarget`

## Requirements
- R1: After reset the block does not pull the data line low and does not raise the write strobe.
- R2: An address byte whose upper seven bits differ from the parameter address gets no acknowledge. Neither that byte nor any later byte before the next START is acknowledged or written.
- R3: The block pulls the data line low during the ninth clock after a matching address byte and after every byte it receives in a write. It releases the line after the falling edge that ends that clock.
- R4: In a write transfer, the first byte after the address (R/W bit 0) loads the 8-bit pointer and is not written to the register file.
- R5: Each later write byte is written once at the current pointer, and the pointer then increases by one.
- R6: In a read (R/W bit 1), each byte is taken from the pointer and sent most significant bit first, and the pointer then increases by one.
- R7: When the master NACKs a read byte, the block releases the data line and drives no further bits until the next START.
- R8: The pointer wraps from 0xFF to 0x00.
- R9: A START or repeated START at any point returns the block to address matching with the pointer value kept.
- R10: A STOP ends the transfer. Bus clocks that follow it without a START are neither acknowledged nor written.
- R11: The register write strobe lasts exactly one system clock per stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 turns on the open-drain pull-down of the data line |
| regAddr | output | 8 | Register file address, always the current pointer |
| regWdata | output | 8 | Byte to store |
| regWe | output | 1 | One-cycle store strobe |
| regRdata | input | 8 | Combinational read data at regAddr |

## Verification
The write path is tested with a plain multi-byte burst and with a burst that crosses 0xFF. Together they show whether the pointer byte is kept out of the register file and whether the pointer wraps. Reads are tested after a pointer-setting write and repeated START, and also alone after a STOP. This separates a pointer that is kept from one that is reset, and shows that each byte advances the pointer once, including the byte the master NACKs. A foreign address, and bus clocks sent after a STOP with no START, must draw neither an acknowledge nor a write. Clocking the bus after a final NACK must return only released bits.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } tgtState_e;

  typedef struct packed {
    logic clrBits;
    logic countBit;
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic writeReg;
  } dpStrobe_t;

endpackage

// File: rtl/i2cTgtSync.sv
module i2cTgtSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclS;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  // START: data falls while the clock stays high; STOP: data rises likewise
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaS,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              txBit,
  output logic [PTR_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe
);

  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (stb.clrBits) begin
      bitCnt <= '0;
    end else if (stb.countBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (stb.shiftIn) begin
      rxByte <= {rxByte[DATA_W-2:0], sdaS};
    end
  end

  // pointer: loaded by the first write byte, natural wrap on increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= PTR_W'(rxByte);
    end else if (stb.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '1;
    end else if (stb.loadTx) begin
      txReg <= regRdata;
    end else if (stb.shiftTx) begin
      txReg <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  assign txBit    = txReg[DATA_W-1];
  assign regAddr  = ptr;
  assign regWdata = rxByte;
  assign regWe    = stb.writeReg;

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.loadPtr || stb.incPtr) |-> $stable(ptr));

  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W + 1));

endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h42,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaS,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaDriveLow
);

  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_DONE  = CNT_W'(DATA_W + 1);

  tgtState_e state, nxt;
  logic readMode;
  logic firstByte;
  logic masterAck;

  always_comb begin
    stb = '0;
    nxt = state;
    if (startSeen) begin
      nxt = ST_ADDR;
      stb.clrBits = 1'b1;
    end else if (stopSeen) begin
      nxt = ST_IDLE;
      stb.clrBits = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt < BYTE_DONE) begin
            stb.shiftIn  = 1'b1;
            stb.countBit = 1'b1;
          end
          if (sclFall && bitCnt == BYTE_DONE) begin
            if (state == ST_ADDR) begin
              nxt = (rxByte[DATA_W-1:1] == SLAVE_ADDR) ? ST_AACK : ST_IDLE;
            end else begin
              nxt = ST_RACK;
              if (firstByte) begin
                stb.loadPtr = 1'b1;
              end else begin
                stb.writeReg = 1'b1;
                stb.incPtr   = 1'b1;
              end
            end
          end
        end
        ST_AACK, ST_RACK: begin
          if (sclRise) stb.countBit = 1'b1;
          if (sclFall && bitCnt == ACK_DONE) begin
            stb.clrBits = 1'b1;
            if (state == ST_AACK && readMode) begin
              nxt = ST_TX;
              stb.loadTx = 1'b1;
              stb.incPtr = 1'b1;
            end else begin
              nxt = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt < BYTE_DONE) stb.countBit = 1'b1;
          if (sclFall && bitCnt < BYTE_DONE) stb.shiftTx = 1'b1;
          if (sclFall && bitCnt == BYTE_DONE) nxt = ST_MACK;
        end
        ST_MACK: begin
          if (sclRise) stb.countBit = 1'b1;
          if (sclFall && bitCnt == ACK_DONE) begin
            stb.clrBits = 1'b1;
            if (masterAck) begin
              nxt = ST_TX;
              stb.loadTx = 1'b1;
              stb.incPtr = 1'b1;
            end else begin
              nxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      readMode  <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && nxt == ST_AACK) readMode <= rxByte[0];
      if (state == ST_AACK && nxt == ST_RX) firstByte <= 1'b1;
      else if (stb.loadPtr) firstByte <= 1'b0;
      if (state == ST_MACK && sclRise) masterAck <= ~sdaS;
    end
  end

  assign sdaDriveLow = (state == ST_AACK) || (state == ST_RACK) ||
                       (state == ST_TX && !txBit);

  // R9
  start_resets_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> state == ST_ADDR);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen) |=> state == ST_IDLE);

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaDriveLow);

  // R7
  nack_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK && sclFall && bitCnt == ACK_DONE && !masterAck &&
     !startSeen && !stopSeen) |=> state == ST_IDLE);

  // R4
  ptr_byte_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |-> (state == ST_RX && !firstByte));

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h42,
  parameter int         PTR_W       = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        CNT_W       = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [PTR_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  logic sdaS, sclRise, sclFall, startSeen, stopSeen;
  dpStrobe_t stb;
  logic [DATA_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;
  logic txBit;

  i2cTgtSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2cTgtCtrl #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaS(sdaS),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit),
    .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

  i2cTgtData #(.PTR_W(PTR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS), .regRdata(regRdata),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe)
  );

endmodule

// File: tb/i2cRegTarget_test.sv
module i2cRegTarget_test;

  localparam logic [6:0] DEV = 7'h42;
  localparam int QTR = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow;
  logic [7:0] regAddr, regWdata, regRdata;
  logic regWe;

  assign sdaBus = sdaM & ~sdaDriveLow;

  i2cRegTarget #(.SLAVE_ADDR(DEV)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  // local register file and behavioural model
  logic [7:0] regFile [256];
  logic [7:0] expMem  [256];
  int expPtr;
  int wrQ[$];
  int total = 0;
  int bad = 0;
  logic prevWe = 1'b0;

  assign regRdata = regFile[regAddr];

  always @(posedge clk) if (regWe) regFile[regAddr] <= regWdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of stores against the expected store queue
  always @(negedge clk) begin
    if (rstN) begin
      if (regWe) begin
        int e;
        check(!prevWe, "R11 strobe longer than one cycle", 1, 0);
        if (wrQ.size() == 0) begin
          check(1'b0, "R2/R4/R10 unexpected store", {regAddr, regWdata}, 0);
        end else begin
          e = wrQ.pop_front();
          check({regAddr, regWdata} == 16'(e), "R5 store addr/data",
                {regAddr, regWdata}, e);
        end
      end
      prevWe <= regWe;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; wq(QTR); sclM = 1'b1; wq(QTR);
    sdaM = 1'b0; wq(QTR); sclM = 1'b0; wq(QTR);
  endtask

  task automatic stopC();
    sdaM = 1'b0; wq(QTR); sclM = 1'b1; wq(QTR);
    sdaM = 1'b1; wq(QTR);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; wq(QTR); sclM = 1'b1; wq(2 * QTR); sclM = 1'b0; wq(QTR);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; wq(QTR); sclM = 1'b1; wq(QTR);
    b = sdaBus; wq(QTR); sclM = 1'b0; wq(QTR);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(~ackIt);
  endtask

  task automatic doWrite(input logic [7:0] p, input logic [7:0] d0,
                         input logic [7:0] d1, input logic [7:0] d2, input int n);
    logic ack;
    logic [7:0] d;
    startC();
    writeByte({DEV, 1'b0}, ack);
    check(ack, "R3 address ack", ack, 1);
    writeByte(p, ack);
    check(ack, "R4 pointer byte ack", ack, 1);
    check(sdaDriveLow == 1'b0, "R3 release after ack", sdaDriveLow, 0);
    expPtr = p;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      wrQ.push_back(expPtr * 256 + d);
      expMem[expPtr] = d;
      expPtr = (expPtr + 1) & 255;
      writeByte(d, ack);
      check(ack, "R5 data byte ack", ack, 1);
    end
    stopC();
    wq(8);
    check(wrQ.size() == 0, "R4/R5 stores completed", wrQ.size(), 0);
    check(sdaDriveLow == 1'b0, "R10 released after stop", sdaDriveLow, 0);
  endtask

  task automatic doRead(input bit withPtr, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] got;
    logic b;
    startC();
    if (withPtr) begin
      writeByte({DEV, 1'b0}, ack);
      check(ack, "R3 address ack", ack, 1);
      writeByte(p, ack);
      check(ack, "R4 pointer byte ack", ack, 1);
      expPtr = p;
      startC();
    end
    writeByte({DEV, 1'b1}, ack);
    check(ack, "R9 read address ack after start", ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, got);
      check(got == expMem[expPtr], "R6 read byte", got, expMem[expPtr]);
      expPtr = (expPtr + 1) & 255;
    end
    wq(6);
    check(sdaDriveLow == 1'b0, "R7 released after nack", sdaDriveLow, 0);
    for (int i = 0; i < 8; i++) begin
      recvBit(b);
      check(b == 1'b1, "R7 no data after nack", b, 1);
    end
    stopC();
    wq(8);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) begin
      regFile[i] = 8'(i * 7 + 3);
      expMem[i]  = 8'(i * 7 + 3);
    end
    rstN = 1'b0;
    wq(5);
    check(sdaDriveLow == 1'b0, "R1 reset sda", sdaDriveLow, 0);
    check(regWe == 1'b0, "R1 reset strobe", regWe, 0);
    rstN = 1'b1;
    wq(20);

    // plain burst write then read-back via repeated start
    doWrite(8'h10, 8'hA5, 8'h3C, 8'h00, 3);
    doRead(1'b1, 8'h10, 3);
    // read continuing from kept pointer (0x13) after a stop
    doRead(1'b0, 8'h00, 2);

    // foreign address: no ack, no store
    startC();
    writeByte({7'h43, 1'b0}, ack);
    check(!ack, "R2 foreign address nack", ack, 0);
    writeByte(8'h55, ack);
    check(!ack, "R2 later byte nack", ack, 0);
    writeByte(8'h66, ack);
    check(!ack, "R2 no store", ack, 0);
    stopC();
    wq(8);

    // bus clocks after stop without start
    writeByte({DEV, 1'b0}, ack);
    check(!ack, "R10 no ack without start", ack, 0);
    writeByte(8'h77, ack);
    check(!ack, "R10 no ack second byte", ack, 0);
    stopC();
    wq(8);

    // wrap across 0xFF
    doWrite(8'hFE, 8'h11, 8'h22, 8'h33, 3);
    doRead(1'b1, 8'hFF, 2);
    check(expPtr == 1, "R8 pointer wrapped", expPtr, 1);

    // repeated start in the middle of a write keeps the pointer
    startC();
    writeByte({DEV, 1'b0}, ack);
    writeByte(8'h30, ack);
    wrQ.push_back(16'h30C7);
    expMem[8'h30] = 8'hC7;
    expPtr = 8'h31;
    writeByte(8'hC7, ack);
    check(ack, "R5 data ack before restart", ack, 1);
    doRead(1'b0, 8'h00, 2);
    check(wrQ.size() == 0, "R9 store before restart done", wrQ.size(), 0);

    wq(20);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule